// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block is the target side of a two-wire management bus. It lets a host read and write a small bank of 8-bit control registers. The bank drives parallel outputs, for example enable bits for downstream clock drivers. Both bus wires are open-drain. The block samples them on its own system clock and pulls the data line low through `sda_oe_o`. It never holds the clock line low.

A transfer opens with a start condition. The block then takes a 7-bit address and a direction bit, and acknowledges only its own address. A write carries a command byte next. Bit 7 of that byte picks the mode and bits [6:0] give the starting register offset. In single-byte mode exactly one register is written or read. In block mode the first data byte carries a count, and the offset steps up by one after each register byte. To read, the host first writes the command and then issues a repeated start with the read bit set. Any start or stop condition ends the byte in progress and discards it.

Top module: `mgmt_serial_slave`

## Requirements
- R1: On reset every register takes its parameter value. With the defaults the bank is register 0 = 0xFF (all clock outputs enabled), register 1 = 0x3C, register 2 = 0xA5 and register 3 = 0x00. The bank is exposed on `regs_o` with register i at bits [8i+7:8i].
- R2: The slave pulls SDA low in the ninth clock of an address byte only when bits [7:1] of that byte equal `SLAVE_ADDR`. On any other address it acknowledges nothing, drives no data and changes no register until the next start condition.
- R3: In single-byte mode (command bit 7 = 1), command bits [6:0] select the register, taken modulo `NUM_REGS`. The first data byte is acknowledged and written there. Any further data byte in the same write is not acknowledged and not written.
- R4: A single-byte read works as follows. The host writes the command, then issues a repeated start and the address with bit 0 = 1. The slave acknowledges and returns the selected register MSB first.
- R5: In block write mode (command bit 7 = 0), the first data byte is a count N. The next N bytes are written to consecutive registers starting at the offset and wrapping past the last register. Every one of these bytes is acknowledged. Bytes beyond N are neither acknowledged nor written.
- R6: A block read first returns the byte `NUM_REGS`. It then returns registers starting at the offset, incrementing and wrapping, for as long as the host acknowledges.
- R7: After the host leaves a read byte unacknowledged, the slave keeps SDA released until a stop or start condition. SDA is also released in the cycle after any stop.
- R8: A start or stop condition in the middle of a byte aborts the transfer with no register change. The next transfer works normally.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: A register changes only while SCL is low, and at most one register changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | 8*NUM_REGS | Register bank contents, register i in byte i |

## Verification
The assertions rely on the bus being slow compared with `clk`. Each SCL low and high phase must last longer than the synchronizer delay of three cycles, so that a change timed on the synchronized falling edge still falls inside the raw low phase. They also rely on the host changing SDA only while SCL is low, except when it forms a start or stop, and on the host never issuing a stop while the slave holds SDA low. The stimulus keeps every SCL phase at eight clocks. It changes SDA two clocks after SCL falls, and it only ends a transfer after the slave has released the line.

// File: rtl/msl_pkg.sv
package msl_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Protocol phase of the slave engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_WDATA,
        PH_RDATA,
        PH_SKIP
    } phase_e;

    // Bus events decoded from the synchronized lines
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Command bit 7 set selects single-byte mode
    function automatic logic cmd_is_single(input logic [7:0] cmd);
        return cmd[7];
    endfunction
endpackage

// File: rtl/msl_bus_sync.sv
module msl_bus_sync
    import msl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o,
    output logic    sda_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    always_comb begin
        ev_o.scl_rise = scl_ff[1] & ~scl_q;
        ev_o.scl_fall = ~scl_ff[1] & scl_q;
        ev_o.start    = scl_q & scl_ff[1] & sda_q & ~sda_ff[1];
        ev_o.stop     = scl_q & scl_ff[1] & ~sda_q & sda_ff[1];
        sda_o         = sda_ff[1];
    end
endmodule

// File: rtl/msl_regbank.sv
module msl_regbank #(
    parameter int                      NUM_REGS  = 4,
    parameter logic [NUM_REGS*8-1:0]   RST_VALUE = '1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en_i,
    input  logic [$clog2(NUM_REGS)-1:0] idx_i,
    input  logic [7:0]                  wr_data_i,
    output logic [7:0]                  rd_data_o,
    output logic [NUM_REGS*8-1:0]       regs_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = $clog2(NUM_REGS);

    logic [7:0] mem [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= RST_VALUE[i*8 +: 8];
            else if (wr_en_i && idx_i == IDX_W'(i))
                mem[i] <= wr_data_i;
        end
        assign regs_o[i*8 +: 8] = mem[i];
    end

    assign rd_data_o = mem[idx_i];
endmodule

// File: rtl/msl_engine.sv
module msl_engine
    import msl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int         NUM_REGS   = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  bus_ev_t                     ev_i,
    input  logic                        sda_i,
    input  logic [7:0]                  rd_data_i,
    output logic                        wr_en_o,
    output logic [$clog2(NUM_REGS)-1:0] idx_o,
    output logic [7:0]                  wr_data_o,
    output logic                        sda_oe_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int         IDX_W    = $clog2(NUM_REGS);
    localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

    phase_e     phase;
    logic [3:0] bitcnt;      // rising edges in this byte; 9 marks the ack slot
    logic [7:0] rx_sh, tx_sh, remain;
    logic [6:0] offset;
    logic       rd_dir, single, first, mack, oe;

    logic       at_ack, at_end, addr_hit, accept, count_first;
    logic [7:0] next_tx;

    always_comb begin
        at_ack      = ev_i.scl_fall && bitcnt == 4'd8;
        at_end      = ev_i.scl_fall && bitcnt == 4'd9;
        addr_hit    = rx_sh[7:1] == SLAVE_ADDR;
        accept      = single ? first : (first || remain != 8'd0);
        count_first = !single && first;
        next_tx     = count_first ? CNT_BYTE : rd_data_i;
        wr_en_o     = at_ack && phase == PH_WDATA && accept && !count_first;
        wr_data_o   = rx_sh;
        idx_o       = offset[IDX_W-1:0];
        sda_oe_o    = oe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            remain <= '0;
            offset <= '0;
            rd_dir <= 1'b0;
            single <= 1'b1;
            first  <= 1'b0;
            mack   <= 1'b0;
            oe     <= 1'b0;
        end else if (ev_i.stop) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            oe     <= 1'b0;
        end else if (ev_i.start) begin
            phase  <= PH_ADDR;
            bitcnt <= '0;
            oe     <= 1'b0;
        end else if (phase != PH_IDLE && phase != PH_SKIP) begin
            if (ev_i.scl_rise) begin
                if (bitcnt < 4'd8) begin
                    rx_sh  <= {rx_sh[6:0], sda_i};
                    bitcnt <= bitcnt + 4'd1;
                end else if (bitcnt == 4'd9) begin
                    mack <= !sda_i;
                end
            end
            if (at_ack) begin
                bitcnt <= 4'd9;
                case (phase)
                    PH_ADDR: begin
                        if (addr_hit) begin
                            oe     <= 1'b1;
                            rd_dir <= rx_sh[0];
                            first  <= 1'b1;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_CMD: begin
                        oe     <= 1'b1;
                        single <= cmd_is_single(rx_sh);
                        offset <= rx_sh[6:0];
                        first  <= 1'b1;
                    end
                    PH_WDATA: begin
                        oe    <= accept;
                        first <= 1'b0;
                        if (!single) begin
                            if (first)
                                remain <= rx_sh;
                            else if (remain != 8'd0) begin
                                remain <= remain - 8'd1;
                                offset <= offset + 7'd1;
                            end
                        end
                    end
                    default: oe <= 1'b0;
                endcase
            end else if (at_end) begin
                bitcnt <= '0;
                oe     <= 1'b0;
                case (phase)
                    PH_ADDR: begin
                        if (rd_dir) begin
                            phase <= PH_RDATA;
                            tx_sh <= next_tx;
                            oe    <= !next_tx[7];
                            first <= 1'b0;
                            if (!single && !count_first)
                                offset <= offset + 7'd1;
                        end else begin
                            phase <= PH_CMD;
                        end
                    end
                    PH_CMD: phase <= PH_WDATA;
                    PH_RDATA: begin
                        if (mack) begin
                            tx_sh <= next_tx;
                            oe    <= !next_tx[7];
                            first <= 1'b0;
                            if (!single && !count_first)
                                offset <= offset + 7'd1;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    default: ;
                endcase
            end else if (ev_i.scl_fall && phase == PH_RDATA &&
                         bitcnt != 4'd0 && bitcnt < 4'd8) begin
                tx_sh <= {tx_sh[6:0], 1'b0};
                oe    <= !tx_sh[6];
            end
        end
    end
endmodule

// File: rtl/mgmt_serial_slave.sv
module mgmt_serial_slave
    import msl_pkg::*;
#(
    parameter logic [6:0]            SLAVE_ADDR = 7'h69,
    parameter int                    NUM_REGS   = 4,
    parameter logic [NUM_REGS*8-1:0] RST_VALUE  = 32'h00A5_3CFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = $clog2(NUM_REGS);

    bus_ev_t          bus_ev;
    logic             sda_s;
    logic             wr_en;
    logic [IDX_W-1:0] idx;
    logic [7:0]       wr_data, rd_data;
    logic             stop_seen;

    assign stop_seen = bus_ev.stop;

    msl_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (bus_ev),
        .sda_o (sda_s)
    );

    msl_engine #(
        .SLAVE_ADDR (SLAVE_ADDR),
        .NUM_REGS   (NUM_REGS)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (bus_ev),
        .sda_i     (sda_s),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .idx_o     (idx),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o)
    );

    msl_regbank #(
        .NUM_REGS  (NUM_REGS),
        .RST_VALUE (RST_VALUE)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .idx_i     (idx),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );
endmodule

// File: rtl/msl_checker.sv
module msl_checker #(
    parameter int                    NUM_REGS  = 4,
    parameter logic [NUM_REGS*8-1:0] RST_VALUE = '1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] regs_o,
    input logic                  stop_seen
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [NUM_REGS*8-1:0] prev_regs;
    logic                  prev_ok;
    logic [NUM_REGS-1:0]   chg;

    always_ff @(posedge clk) begin
        prev_regs <= regs_o;
        prev_ok   <= !rst;
    end

    always_comb
        for (int i = 0; i < NUM_REGS; i++)
            chg[i] = prev_regs[i*8 +: 8] != regs_o[i*8 +: 8];

    AST_RESET_VALUE: assert property (@(posedge clk) rst |=> (regs_o == RST_VALUE)); // R1
    AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe_o) |-> !scl_i); // R9
    AST_REG_MOVES_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(regs_o) |-> !scl_i); // R10
    AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (rst) prev_ok |-> $onehot0(chg)); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst) stop_seen |=> !sda_oe_o); // R7
endmodule

bind mgmt_serial_slave msl_checker #(
    .NUM_REGS  (NUM_REGS),
    .RST_VALUE (RST_VALUE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .regs_o    (regs_o),
    .stop_seen (stop_seen)
);

// File: tb/sim_mgmt_serial_slave.sv
module sim_mgmt_serial_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic [31:0] regs;

    int checks = 0;
    int errors = 0;
    int viol9  = 0;
    int viol10 = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    mgmt_serial_slave u0 (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    // Monitors for R9 and R10 at the ports
    logic        prev_oe = 1'b0;
    logic [31:0] prev_regs = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe != prev_oe && scl_m) viol9++;
            if (regs != prev_regs) begin
                if (scl_m) viol10++;
                if (((regs[7:0] != prev_regs[7:0]) + (regs[15:8] != prev_regs[15:8]) +
                     (regs[23:16] != prev_regs[23:16]) + (regs[31:24] != prev_regs[31:24])) > 1)
                    viol10++;
            end
        end
        prev_oe   <= sda_oe;
        prev_regs <= regs;
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        if (!scl_m) begin
            sda_m = 1'b1; ticks(H);
            scl_m = 1'b1; ticks(H);
        end
        sda_m = 1'b0; ticks(H);
        scl_m = 1'b0; ticks(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; ticks(H);
        scl_m = 1'b1; ticks(H);
        sda_m = 1'b1; ticks(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; ticks(H);
            scl_m = 1'b1; ticks(H);
            scl_m = 1'b0; ticks(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; ticks(H);
        scl_m = 1'b1; ticks(H/2);
        ack = !sda_line;
        ticks(H/2);
        scl_m = 1'b0; ticks(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            ticks(H);
            scl_m = 1'b1; ticks(H/2);
            d[i] = sda_line;
            ticks(H/2);
            scl_m = 1'b0; ticks(2);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; ticks(H);
        scl_m = 1'b1; ticks(H);
        scl_m = 1'b0; ticks(2);
        sda_m = 1'b1;
    endtask

    task automatic t_reset;
        chk("R1 reset values", regs, 32'h00A5_3CFF);
    endtask

    task automatic t_byte_write;
        logic a;
        bus_start;
        send_byte(8'hD2, a); chk("R2 own address acked", a, 1);
        send_byte(8'h82, a); chk("R3 command acked", a, 1);
        send_byte(8'h11, a); chk("R3 data acked", a, 1);
        send_byte(8'h22, a); chk("R3 second data byte not acked", a, 0);
        bus_stop;
        chk("R3 only register 2 written once", regs, 32'h0011_3CFF);
    endtask

    task automatic t_byte_read(input logic [7:0] cmd, input logic [7:0] exp);
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(cmd, a);
        bus_start;
        send_byte(8'hD3, a); chk("R4 read address acked", a, 1);
        recv_byte(1'b0, d);  chk("R4 byte read data", d, exp);
        bus_stop;
    endtask

    task automatic t_mismatch;
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte(8'hA0, a); chk("R2 foreign address not acked", a, 0);
        send_byte(8'h81, a); chk("R2 command ignored", a, 0);
        send_byte(8'h00, a); chk("R2 data ignored", a, 0);
        bus_stop;
        chk("R2 registers untouched", regs, 32'h0011_3CFF);
        bus_start;
        send_byte(8'hA1, a); chk("R2 foreign read not acked", a, 0);
        recv_byte(1'b0, d);  chk("R2 no data driven", d, 8'hFF);
        bus_stop;
    endtask

    task automatic t_block_write;
        logic a;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h03, a); chk("R5 block command acked", a, 1);
        send_byte(8'h02, a); chk("R5 count acked", a, 1);
        send_byte(8'hAA, a); chk("R5 first byte acked", a, 1);
        send_byte(8'hBB, a); chk("R5 second byte acked", a, 1);
        send_byte(8'hCC, a); chk("R5 byte past count not acked", a, 0);
        bus_stop;
        chk("R5 wrap write result", regs, 32'hAA11_3CBB);
    endtask

    task automatic t_block_read;
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h01, a);
        bus_start;
        send_byte(8'hD3, a);
        recv_byte(1'b1, d); chk("R6 count byte", d, 8'h04);
        recv_byte(1'b1, d); chk("R6 reg1", d, 8'h3C);
        recv_byte(1'b1, d); chk("R6 reg2", d, 8'h11);
        recv_byte(1'b1, d); chk("R6 reg3", d, 8'hAA);
        recv_byte(1'b0, d); chk("R6 wrapped reg0", d, 8'hBB);
        bus_stop;
    endtask

    task automatic t_nack;
        logic a;
        logic [7:0] d;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        bus_start;
        send_byte(8'hD3, a);
        recv_byte(1'b0, d); chk("R7 count before nack", d, 8'h04);
        recv_byte(1'b1, d); chk("R7 line released after nack", d, 8'hFF);
        recv_byte(1'b0, d); chk("R7 still released", d, 8'hFF);
        bus_stop;
        chk("R7 registers unchanged", regs, 32'hAA11_3CBB);
    endtask

    task automatic t_abort;
        logic a;
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h81, a);
        send_bits(8'h00, 5);
        bus_start;
        bus_stop;
        chk("R8 start mid-byte no write", regs, 32'hAA11_3CBB);
        bus_start;
        send_byte(8'hD2, a);
        send_byte(8'h81, a);
        send_bits(8'h00, 4);
        bus_stop;
        chk("R8 stop mid-byte no write", regs, 32'hAA11_3CBB);
        bus_start;
        send_byte(8'hD2, a); chk("R8 recovery address acked", a, 1);
        send_byte(8'h81, a);
        send_byte(8'h77, a);
        bus_stop;
        chk("R8 recovery write", regs, 32'hAA11_77BB);
    endtask

    initial begin
        ticks(5);
        rst = 1'b0;
        ticks(10);
        t_reset;
        t_byte_write;
        t_byte_read(8'h82, 8'h11);
        t_byte_read(8'h80, 8'hFF);
        t_mismatch;
        t_block_write;
        t_block_read;
        t_nack;
        t_abort;
        chk("R9 SDA drive changes only with SCL low", viol9, 0);
        chk("R10 register changes only with SCL low, one at a time", viol10, 0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule